// File: doc/BRIEF.md
# Phase-Scoped Self-Invalidating L1 Cache Controller

This block is the private level-one data cache controller of one core in a multicore where software runs in parallel phases. Instead of tracking sharers or receiving invalidations from other cores, the controller keeps a per-word coherence state (Invalid, Valid or Registered), a per-word touched flag and a per-word region tag. At the end of each phase it drops its own possibly stale copies in the regions the phase declared as written. Each word moves directly between its three states, with no transient states.

The core issues single-word reads and writes through a request/response port. Read misses fetch one word from the shared L2. Writes make the word Registered and send a registration carrying the data, which the L2 acknowledges later. A line has a single address tag shared by its words. Filling one word leaves its neighbours alone. Reusing a line for another tag first writes back every Registered word it holds. A phase-end strobe with a written-region mask starts a sweep over every word. Then the controller waits until every registration has been acknowledged, pulses `phase_done` and clears all touched flags.

The controller's states are C_IDLE, C_LOOKUP, C_FILL, C_EVICT, C_SWEEP and C_DRAIN. The transitions are:
- C_IDLE goes to C_SWEEP on `phase_end`, otherwise to C_LOOKUP on an accepted request.
- C_LOOKUP goes to C_EVICT on a tag miss, to C_FILL on a read of an Invalid word, and back to C_IDLE on a hit or a completed write.
- C_LOOKUP stays in place while a new registration finds the outstanding-registration tracker full.
- C_EVICT returns to C_LOOKUP after its last word.
- C_FILL returns to C_IDLE when the fill data arrives.
- C_SWEEP goes to C_DRAIN after the last word.
- C_DRAIN goes to C_IDLE with the `phase_done` pulse once no registration is outstanding.

Top module: `phase_l1_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `l2_req_valid` and `phase_done` are 0. Every word starts Invalid, so the first read of any address issues an L2 read.
- R2: A read of an Invalid word issues exactly one L2 request with `l2_req_op` = 0 (read) for that word address. It returns the data delivered on `l2_rsp_data`, and the word becomes Valid, so a repeat read issues no L2 request.
- R3: A write of a word that is not Registered makes it Registered. It issues one L2 request with `l2_req_op` = 1 (registration) carrying the address and the write data. Later reads return the written data without an L2 request.
- R4: A write to a word that is already Registered completes locally and issues no L2 request.
- R5: Filling one word of a line leaves the data and state of the other words of that line unchanged.
- R6: On `phase_end`, every Valid word that was not read since the last `phase_done` and whose region bit is set in `wr_regions` becomes Invalid. Its next read fetches the L2's current value.
- R7: The phase-end sweep keeps three kinds of word: Valid words whose region bit is clear, Valid words read during the phase, and Registered words. A later read of any of them returns the cached value with no L2 request.
- R8: `phase_done` is a one-cycle pulse, raised only after every registration has been acknowledged on `l2_ack`. Touched flags are cleared with it.
- R9: A request whose tag misses a line first sends one request with `l2_req_op` = 2 (writeback) for each Registered word of that line, carrying its address and data. Valid words are dropped without any request. Addresses split as word offset in bits [1:0], line index in bits [4:2] and tag in bits [11:5].
- R10: `req_ready` is 0 while `phase_end` is high and while a phase-end sweep or drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Write data |
| req_region | input | 3 | Region tag of the accessed word |
| resp_valid | output | 1 | One-cycle completion of the accepted request |
| resp_rdata | output | 32 | Read data |
| phase_end | input | 1 | Phase-end strobe |
| wr_regions | input | 8 | Regions written in the ending phase |
| phase_done | output | 1 | Phase end finished |
| l2_req_valid | output | 1 | L2 request strobe |
| l2_req_op | output | 2 | 0 read, 1 registration, 2 writeback |
| l2_req_addr | output | 12 | Word address of the L2 request |
| l2_req_data | output | 32 | Data for registration or writeback |
| l2_rsp_valid | input | 1 | Fill data valid |
| l2_rsp_data | input | 32 | Fill data |
| l2_ack | input | 1 | One registration acknowledged |

## Verification
Two events can meet in one cycle. The first case is a registration issued in the same cycle as an acknowledgement for an earlier one, so the outstanding-registration count goes up and down together. The bench's L2 model releases acknowledgements at random while random writes keep issuing new registrations. A wrong count shows up as `phase_done` arriving while the model still holds unreturned acknowledgements, or never arriving. The second case is `phase_end` raised while a request is waiting. It is judged by `req_ready` falling in that cycle and by the request completing with correct data after the phase ends.

// File: rtl/pl1_pkg.sv
package pl1_pkg;
    typedef enum logic [1:0] {
        W_INV = 2'd0,
        W_VAL = 2'd1,
        W_REG = 2'd2
    } wstate_t;

    typedef enum logic [1:0] {
        L2_READ      = 2'd0,
        L2_REGISTER  = 2'd1,
        L2_WRITEBACK = 2'd2
    } l2op_t;

    typedef enum logic [2:0] {
        AOP_NONE,
        AOP_FILL,
        AOP_WRITE,
        AOP_TOUCH,
        AOP_INVAL,
        AOP_LINECLR
    } arr_op_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_LOOKUP,
        C_FILL,
        C_EVICT,
        C_SWEEP,
        C_DRAIN
    } ctrl_state_t;
endpackage

// File: rtl/pl1_word_array.sv
module pl1_word_array
    import pl1_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int WPL    = 4,
    parameter int DATA_W = 32,
    parameter int REG_W  = 3,
    localparam int NW    = LINES * WPL,
    localparam int IW    = $clog2(NW),
    localparam int OFF_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  arr_op_t           op,
    input  logic [IW-1:0]     op_idx,
    input  logic [DATA_W-1:0] op_data,
    input  logic [REG_W-1:0]  op_region,
    input  logic              clr_touched,
    input  logic [IW-1:0]     rd_idx,
    output wstate_t           rd_state,
    output logic [DATA_W-1:0] rd_data,
    output logic [REG_W-1:0]  rd_region,
    output logic              rd_touched
);
    wstate_t             st_q  [NW];
    logic [DATA_W-1:0]   dat_q [NW];
    logic [REG_W-1:0]    rgn_q [NW];
    logic [NW-1:0]       tch_q;
    logic [IW-1:0]       line_base;

    assign line_base = {op_idx[IW-1:OFF_W], {OFF_W{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                st_q[i]  <= W_INV;
                dat_q[i] <= '0;
                rgn_q[i] <= '0;
            end
            tch_q <= '0;
        end else begin
            if (clr_touched) tch_q <= '0;
            unique case (op)
                AOP_FILL: begin
                    st_q[op_idx]  <= W_VAL;
                    dat_q[op_idx] <= op_data;
                    rgn_q[op_idx] <= op_region;
                    tch_q[op_idx] <= 1'b1;
                end
                AOP_WRITE: begin
                    st_q[op_idx]  <= W_REG;
                    dat_q[op_idx] <= op_data;
                    rgn_q[op_idx] <= op_region;
                end
                AOP_TOUCH: tch_q[op_idx] <= 1'b1;
                AOP_INVAL: st_q[op_idx] <= W_INV;
                AOP_LINECLR: begin
                    for (int o = 0; o < WPL; o++) begin
                        st_q[line_base + IW'(o)]  <= W_INV;
                        tch_q[line_base + IW'(o)] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_state   = st_q[rd_idx];
    assign rd_data    = dat_q[rd_idx];
    assign rd_region  = rgn_q[rd_idx];
    assign rd_touched = tch_q[rd_idx];

    // R3: a write leaves the word Registered
    assert_write_sets_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AOP_WRITE) |=> (st_q[$past(op_idx)] == W_REG));

    // R6: the sweep only invalidates words that are Valid
    assert_inval_was_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == AOP_INVAL) |-> (st_q[op_idx] == W_VAL));
endmodule

// File: rtl/pl1_tag_array.sv
module pl1_tag_array #(
    parameter int LINES = 8,
    parameter int TAG_W = 7,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             set_en,
    output logic             lk_hit,
    output logic [TAG_W-1:0] lk_old_tag
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
            vld_q <= '0;
        end else if (set_en) begin
            tag_q[lk_idx] <= lk_tag;
            vld_q[lk_idx] <= 1'b1;
        end
    end

    assign lk_old_tag = tag_q[lk_idx];
    assign lk_hit     = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/pl1_reg_tracker.sv
module pl1_reg_tracker #(
    parameter int MAX_OUT = 8,
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic ack,
    output logic pending,
    output logic full
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (inc && !ack) cnt_q <= cnt_q + 1'b1;
        else if (ack && !inc) cnt_q <= cnt_q - 1'b1;
    end

    assign pending = (cnt_q != '0);
    assign full    = (cnt_q == CW'(MAX_OUT));

    // R3: no registration is issued beyond the tracker capacity
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (!full || ack));

    // R8: an acknowledgement always matches an outstanding registration
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !inc) |-> pending);
endmodule

// File: rtl/phase_l1_ctrl.sv
module phase_l1_ctrl
    import pl1_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int LINES   = 8,
    parameter int WPL     = 4,
    parameter int REGIONS = 8,
    parameter int MAX_OUT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [$clog2(REGIONS)-1:0] req_region,
    output logic                       resp_valid,
    output logic [DATA_W-1:0]          resp_rdata,
    input  logic                       phase_end,
    input  logic [REGIONS-1:0]         wr_regions,
    output logic                       phase_done,
    output logic                       l2_req_valid,
    output logic [1:0]                 l2_req_op,
    output logic [ADDR_W-1:0]          l2_req_addr,
    output logic [DATA_W-1:0]          l2_req_data,
    input  logic                       l2_rsp_valid,
    input  logic [DATA_W-1:0]          l2_rsp_data,
    input  logic                       l2_ack
);
    localparam int OFF_W = $clog2(WPL);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int NW    = LINES * WPL;
    localparam int IW    = $clog2(NW);
    localparam int REG_W = $clog2(REGIONS);

    ctrl_state_t        state_q, state_d;
    logic               rq_write;
    logic [ADDR_W-1:0]  rq_addr;
    logic [DATA_W-1:0]  rq_wdata;
    logic [REG_W-1:0]   rq_region;
    logic [IW-1:0]      ptr_q, ptr_d;
    logic [REGIONS-1:0] mask_q;
    logic               resp_valid_q;
    logic [DATA_W-1:0]  resp_data_q;
    logic               done_q;
    logic               l2v_q;
    l2op_t              l2op_q;
    logic [ADDR_W-1:0]  l2addr_q;
    logic [DATA_W-1:0]  l2data_q;

    logic [IDX_W-1:0]   idx;
    logic [OFF_W-1:0]   off;
    logic [TAG_W-1:0]   tag;
    logic [IW-1:0]      arr_rd_idx;

    arr_op_t            aop;
    logic [DATA_W-1:0]  aop_data;
    logic               clr_t;
    wstate_t            rd_state;
    logic [DATA_W-1:0]  rd_data;
    logic [REG_W-1:0]   rd_region;
    logic               rd_touched;

    logic               lk_hit;
    logic [TAG_W-1:0]   lk_old_tag;
    logic               tag_set;

    logic               reg_inc;
    logic               regs_pending;
    logic               regs_full;

    logic               accept;
    logic               iss_valid;
    l2op_t              iss_op;
    logic [ADDR_W-1:0]  iss_addr;
    logic [DATA_W-1:0]  iss_data;
    logic               resp_set;
    logic [DATA_W-1:0]  resp_dat;
    logic               done_set;

    assign off = rq_addr[OFF_W-1:0];
    assign idx = rq_addr[OFF_W +: IDX_W];
    assign tag = rq_addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        unique case (state_q)
            C_SWEEP: arr_rd_idx = ptr_q;
            C_EVICT: arr_rd_idx = {idx, ptr_q[OFF_W-1:0]};
            default: arr_rd_idx = {idx, off};
        endcase
    end

    pl1_word_array #(
        .LINES(LINES), .WPL(WPL), .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_words (
        .clk(clk), .rst_n(rst_n),
        .op(aop), .op_idx(arr_rd_idx), .op_data(aop_data), .op_region(rq_region),
        .clr_touched(clr_t),
        .rd_idx(arr_rd_idx), .rd_state(rd_state), .rd_data(rd_data),
        .rd_region(rd_region), .rd_touched(rd_touched)
    );

    pl1_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(idx), .lk_tag(tag), .set_en(tag_set),
        .lk_hit(lk_hit), .lk_old_tag(lk_old_tag)
    );

    pl1_reg_tracker #(.MAX_OUT(MAX_OUT)) u_track (
        .clk(clk), .rst_n(rst_n),
        .inc(reg_inc), .ack(l2_ack),
        .pending(regs_pending), .full(regs_full)
    );

    assign req_ready = (state_q == C_IDLE) && !phase_end;

    // transition and control decode
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        accept    = 1'b0;
        aop       = AOP_NONE;
        aop_data  = rq_wdata;
        clr_t     = 1'b0;
        tag_set   = 1'b0;
        reg_inc   = 1'b0;
        iss_valid = 1'b0;
        iss_op    = L2_READ;
        iss_addr  = rq_addr;
        iss_data  = rq_wdata;
        resp_set  = 1'b0;
        resp_dat  = rq_wdata;
        done_set  = 1'b0;
        unique case (state_q)
            C_IDLE: begin
                if (phase_end) begin
                    state_d = C_SWEEP;
                    ptr_d   = '0;
                end else if (req_valid) begin
                    accept  = 1'b1;
                    state_d = C_LOOKUP;
                end
            end
            C_LOOKUP: begin
                if (!lk_hit) begin
                    state_d = C_EVICT;
                    ptr_d   = '0;
                end else if (rq_write) begin
                    if (rd_state == W_REG) begin
                        aop      = AOP_WRITE;
                        resp_set = 1'b1;
                        state_d  = C_IDLE;
                    end else if (!regs_full) begin
                        aop       = AOP_WRITE;
                        iss_valid = 1'b1;
                        iss_op    = L2_REGISTER;
                        reg_inc   = 1'b1;
                        resp_set  = 1'b1;
                        state_d   = C_IDLE;
                    end
                end else if (rd_state != W_INV) begin
                    aop      = AOP_TOUCH;
                    resp_set = 1'b1;
                    resp_dat = rd_data;
                    state_d  = C_IDLE;
                end else begin
                    iss_valid = 1'b1;
                    iss_op    = L2_READ;
                    state_d   = C_FILL;
                end
            end
            C_FILL: begin
                if (l2_rsp_valid) begin
                    aop      = AOP_FILL;
                    aop_data = l2_rsp_data;
                    resp_set = 1'b1;
                    resp_dat = l2_rsp_data;
                    state_d  = C_IDLE;
                end
            end
            C_EVICT: begin
                if (rd_state == W_REG) begin
                    iss_valid = 1'b1;
                    iss_op    = L2_WRITEBACK;
                    iss_addr  = {lk_old_tag, idx, ptr_q[OFF_W-1:0]};
                    iss_data  = rd_data;
                end
                ptr_d = ptr_q + 1'b1;
                if (ptr_q[OFF_W-1:0] == OFF_W'(WPL - 1)) begin
                    aop     = AOP_LINECLR;
                    tag_set = 1'b1;
                    state_d = C_LOOKUP;
                end
            end
            C_SWEEP: begin
                if (rd_state == W_VAL && mask_q[rd_region] && !rd_touched)
                    aop = AOP_INVAL;
                ptr_d = ptr_q + 1'b1;
                if (ptr_q == IW'(NW - 1)) state_d = C_DRAIN;
            end
            C_DRAIN: begin
                if (!regs_pending) begin
                    done_set = 1'b1;
                    clr_t    = 1'b1;
                    state_d  = C_IDLE;
                end
            end
            default: state_d = C_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // registered outputs and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_write     <= 1'b0;
            rq_addr      <= '0;
            rq_wdata     <= '0;
            rq_region    <= '0;
            mask_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            done_q       <= 1'b0;
            l2v_q        <= 1'b0;
            l2op_q       <= L2_READ;
            l2addr_q     <= '0;
            l2data_q     <= '0;
        end else begin
            if (accept) begin
                rq_write  <= req_write;
                rq_addr   <= req_addr;
                rq_wdata  <= req_wdata;
                rq_region <= req_region;
            end
            if (state_q == C_IDLE && phase_end) mask_q <= wr_regions;
            resp_valid_q <= resp_set;
            if (resp_set) resp_data_q <= resp_dat;
            done_q <= done_set;
            l2v_q  <= iss_valid;
            if (iss_valid) begin
                l2op_q   <= iss_op;
                l2addr_q <= iss_addr;
                l2data_q <= iss_data;
            end
        end
    end

    assign resp_valid   = resp_valid_q;
    assign resp_rdata   = resp_data_q;
    assign phase_done   = done_q;
    assign l2_req_valid = l2v_q;
    assign l2_req_op    = l2op_q;
    assign l2_req_addr  = l2addr_q;
    assign l2_req_data  = l2data_q;

    // R8: phase completion only with no registration outstanding
    assert_done_after_acks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> !regs_pending);

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done);

    // R2: a read miss issues one request and then waits for its fill
    assert_read_then_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && l2_req_op == 2'd0) |=> !l2_req_valid);
endmodule

// File: tb/phase_l1_ctrl_bench.sv
module phase_l1_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_region = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        phase_end = 1'b0;
    logic [7:0]  wr_regions = '0;
    logic        phase_done;
    logic        l2_req_valid;
    logic [1:0]  l2_req_op;
    logic [11:0] l2_req_addr;
    logic [31:0] l2_req_data;
    logic        l2_rsp_valid = 1'b0;
    logic [31:0] l2_rsp_data = '0;
    logic        l2_ack = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_l1_ctrl u_phase_l1_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_region(req_region),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .phase_end(phase_end), .wr_regions(wr_regions), .phase_done(phase_done),
        .l2_req_valid(l2_req_valid), .l2_req_op(l2_req_op),
        .l2_req_addr(l2_req_addr), .l2_req_data(l2_req_data),
        .l2_rsp_valid(l2_rsp_valid), .l2_rsp_data(l2_rsp_data), .l2_ack(l2_ack)
    );

    int tests = 0;
    int fails = 0;
    bit timed_out = 1'b0;

    // L2 model state
    logic [31:0] mem [4096];
    int          n_reads = 0, n_regs = 0, n_wbs = 0;
    int          ack_pend = 0;
    bit          ack_hold = 1'b0;
    int          rd_timer = 0;
    logic [11:0] rd_addr = '0;
    logic [11:0] last_rd_addr = '0, last_reg_addr = '0, last_wb_addr = '0;
    logic [31:0] last_reg_data = '0, last_wb_data = '0;

    // random-phase reference
    bit          wrote [4096];
    logic [31:0] wval  [4096];

    function automatic logic [31:0] init_val(input int a);
        return 32'h5A00_0000 ^ (32'(a) * 32'h0100_0193);
    endfunction

    always @(negedge clk) begin
        l2_ack       = 1'b0;
        l2_rsp_valid = 1'b0;
        if (ack_pend > 0 && !ack_hold && ($urandom % 2 == 0)) begin
            l2_ack   = 1'b1;
            ack_pend = ack_pend - 1;
        end
        if (rd_timer > 0) begin
            rd_timer = rd_timer - 1;
            if (rd_timer == 0) begin
                l2_rsp_valid = 1'b1;
                l2_rsp_data  = mem[rd_addr];
            end
        end
        if (l2_req_valid) begin
            case (l2_req_op)
                2'd0: begin
                    n_reads++; rd_addr = l2_req_addr; last_rd_addr = l2_req_addr;
                    rd_timer = 2;
                end
                2'd1: begin
                    n_regs++; ack_pend++;
                    last_reg_addr = l2_req_addr; last_reg_data = l2_req_data;
                end
                default: begin
                    n_wbs++; mem[l2_req_addr] = l2_req_data;
                    last_wb_addr = l2_req_addr; last_wb_data = l2_req_data;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int a, input logic [31:0] d,
                          input logic [2:0] rg, output logic [31:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 12'(a);
        req_wdata = d; req_region = rg;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        q = resp_rdata;
        @(negedge clk);
    endtask

    task automatic do_phase(input logic [7:0] m, input bit hold_first);
        @(negedge clk);
        phase_end = 1'b1; wr_regions = m;
        #1;
        chk(req_ready == 1'b0, "R10 ready low with phase_end", 32'(req_ready), 0);
        @(negedge clk);
        phase_end = 1'b0;
        if (hold_first) begin
            repeat (60) begin
                @(negedge clk);
                chk(phase_done == 1'b0, "R8 done held by missing ack", 32'(phase_done), 0);
                if (phase_done) break;
            end
            chk(req_ready == 1'b0, "R10 not ready while draining", 32'(req_ready), 0);
            ack_hold = 1'b0;
        end
        while (!phase_done) @(negedge clk);
        chk(ack_pend == 0, "R8 all acks in at done", 32'(ack_pend), 0);
        @(negedge clk);
        chk(phase_done == 1'b0, "R8 done is one pulse", 32'(phase_done), 0);
    endtask

    task automatic run_all();
        logic [31:0] q;
        int r0, g0, w0;
        int a;
        logic [31:0] v;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = init_val(i); wrote[i] = 1'b0; wval[i] = '0;
        end
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(resp_valid == 1'b0 && l2_req_valid == 1'b0 && phase_done == 1'b0,
            "R1 outputs idle after reset", {29'd0, resp_valid, l2_req_valid, phase_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: first read misses and fills
        r0 = n_reads;
        access(1'b0, 12'h010, '0, 3'd0, q);
        chk(q == init_val(12'h010), "R2 fill data", q, init_val(12'h010));
        chk(n_reads == r0 + 1, "R1 first read goes to L2", 32'(n_reads - r0), 1);
        chk(last_rd_addr == 12'h010, "R2 read address", 32'(last_rd_addr), 32'h010);
        access(1'b0, 12'h010, '0, 3'd0, q);
        chk(n_reads == r0 + 1 && q == init_val(12'h010), "R2 repeat read hits",
            32'(n_reads - r0), 1);

        // R3: write registers
        g0 = n_regs; r0 = n_reads;
        access(1'b1, 12'h011, 32'hCAFE0001, 3'd1, q);
        chk(n_regs == g0 + 1, "R3 one registration", 32'(n_regs - g0), 1);
        chk(last_reg_addr == 12'h011 && last_reg_data == 32'hCAFE0001,
            "R3 registration payload", last_reg_data, 32'hCAFE0001);
        access(1'b0, 12'h011, '0, 3'd1, q);
        chk(q == 32'hCAFE0001 && n_reads == r0, "R3 read own write", q, 32'hCAFE0001);

        // R4: rewrite registered word
        g0 = n_regs;
        access(1'b1, 12'h011, 32'hCAFE0002, 3'd1, q);
        chk(n_regs == g0, "R4 no new registration", 32'(n_regs - g0), 0);
        access(1'b0, 12'h011, '0, 3'd1, q);
        chk(q == 32'hCAFE0002, "R4 new data kept", q, 32'hCAFE0002);

        // R5: neighbour fill leaves other words alone
        access(1'b0, 12'h012, '0, 3'd0, q);
        chk(q == init_val(12'h012), "R5 neighbour fill data", q, init_val(12'h012));
        r0 = n_reads;
        access(1'b0, 12'h011, '0, 3'd1, q);
        chk(q == 32'hCAFE0002 && n_reads == r0, "R5 registered word intact", q, 32'hCAFE0002);
        access(1'b0, 12'h010, '0, 3'd0, q);
        chk(q == init_val(12'h010) && n_reads == r0, "R5 valid word intact",
            q, init_val(12'h010));

        // R6, R7: phase-end self-invalidation
        access(1'b0, 12'h020, '0, 3'd1, q);
        access(1'b0, 12'h024, '0, 3'd2, q);
        do_phase(8'h00, 1'b0);
        access(1'b0, 12'h028, '0, 3'd1, q);
        mem[12'h020] = 32'h1111_0001;
        mem[12'h024] = 32'h1111_0002;
        mem[12'h028] = 32'h1111_0003;
        do_phase(8'h02, 1'b0);
        r0 = n_reads;
        access(1'b0, 12'h024, '0, 3'd2, q);
        chk(q == init_val(12'h024) && n_reads == r0, "R7 unmasked region kept",
            q, init_val(12'h024));
        access(1'b0, 12'h028, '0, 3'd1, q);
        chk(q == init_val(12'h028) && n_reads == r0, "R7 touched word kept",
            q, init_val(12'h028));
        access(1'b0, 12'h011, '0, 3'd1, q);
        chk(q == 32'hCAFE0002 && n_reads == r0, "R7 registered word kept", q, 32'hCAFE0002);
        access(1'b0, 12'h020, '0, 3'd1, q);
        chk(q == 32'h1111_0001, "R6 stale word refetched", q, 32'h1111_0001);
        chk(n_reads == r0 + 1, "R6 refetch went to L2", 32'(n_reads - r0), 1);

        // R8: phase_done waits for a held ack
        ack_hold = 1'b1;
        access(1'b1, 12'h038, 32'hBEEF0038, 3'd3, q);
        do_phase(8'h08, 1'b1);

        // R9: eviction writes back registered words only
        w0 = n_wbs;
        access(1'b0, 12'h031, '0, 3'd0, q);
        chk(q == init_val(12'h031), "R9 new line data", q, init_val(12'h031));
        chk(n_wbs == w0 + 1, "R9 one writeback", 32'(n_wbs - w0), 1);
        chk(last_wb_addr == 12'h011 && last_wb_data == 32'hCAFE0002,
            "R9 writeback payload", last_wb_data, 32'hCAFE0002);
        r0 = n_reads;
        access(1'b0, 12'h011, '0, 3'd1, q);
        chk(q == 32'hCAFE0002 && n_reads == r0 + 1, "R9 evicted word refetched",
            q, 32'hCAFE0002);

        // random mix: reads, writes, evictions, phase ends
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom % 100);
            a = 12'h100 + int'($urandom % 64);
            if (r < 3) begin
                do_phase(8'($urandom), 1'b0);
            end else if (r < 45) begin
                v = $urandom;
                access(1'b1, a, v, 3'(a % 8), q);
                wrote[a] = 1'b1; wval[a] = v;
            end else begin
                access(1'b0, a, '0, 3'(a % 8), q);
                v = wrote[a] ? wval[a] : init_val(a);
                chk(q == v, "R2 R3 R9 random read value", q, v);
            end
        end
        do_phase(8'hFF, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WDOG) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", WDOG);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule